// File: doc/BRIEF.md
# Shadow-Commit Wide Control Register

This block holds one control field that is wider than the 32-bit CPU bus, 224 bits by default, which is seven bus words. The CPU fills a shadow copy one 32-bit word at a time. A word index picks the word, and optional byte enables pick the bytes within it. The live copy is the register the datapath sees. It changes only when the CPU raises a commit strobe, and on that clock edge the whole shadow is copied across at once. The datapath therefore never sees a field that is partly old and partly new.

Reads through the word port return the shadow, not the live copy. The CPU can read back and check everything it has staged before it commits. A build parameter removes byte-enable support. In that build every write replaces the whole selected word and the byte enables are ignored. The last word may be narrower than the bus when the field width is not a multiple of 32. Its unused upper bits read as zero.

The design keeps its structure flat and has no sequencing state. Each edge either writes one shadow word, copies the shadow to the live copy, does both, or does nothing. The block has no states or transitions to name.

Top module: `scr_wide_reg`

## Requirements
- R1: After reset the live value is all zeros and every shadow word reads back as zero.
- R2: With byte enables built in, a write with `wr_en` high changes only the bytes of shadow word `wr_idx` whose `wr_be` bit is set. Bit k of `wr_be` covers data bits 8k+7 to 8k. The new contents appear on `rd_data` after that clock edge.
- R3: On any edge where `commit` is low, `live_val` keeps its value, whatever writes happen to the shadow.
- R4: On an edge where `commit` is high, `live_val` takes the full shadow value, from all words together, and shows it after that edge. Repeating a commit with no write in between leaves `live_val` unchanged.
- R5: If a write and a commit fall on the same edge, `live_val` receives the shadow as it stood before that write. The written data lands in the shadow only and needs a later commit to go live.
- R6: A write whose word index is 7 or more (at or beyond the word count) changes nothing. A read with such an index returns zero.
- R7: When byte enables are built out (`USE_BYTE_EN` = 0), `wr_be` is ignored and each write replaces the whole selected word.
- R8: `rd_data` returns the shadow word chosen by `rd_idx`, combinationally. Staged but uncommitted data reads back while `live_val` still holds the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one shadow word |
| wr_idx | input | 3 | Index of the shadow word to write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables, bit k for byte k |
| commit | input | 1 | Copy the whole shadow into the live value |
| rd_idx | input | 3 | Index of the shadow word to read back |
| rd_data | output | 32 | Shadow word selected by `rd_idx` |
| live_val | output | 224 | Live field driven to the datapath |

## Verification
A shadow write is captured on the rising edge where `wr_en` is high. It is visible on `rd_data` from that edge on, because the read path is combinational from `rd_idx`. A commit updates `live_val` after exactly one edge. The bench raises the strobes 2 ns after one rising edge and drops them 1 ns after the next. It holds `rd_idx` steady and pushes the expected shadow word and live value at that point. A monitor compares them on the following falling edge. The bench drives the same stimulus into a second copy built without byte enables and checks it against its own model, which covers R7.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

    // number of bus words needed to cover a field
    function automatic int word_count(input int field_w, input int bus_w);
        return (field_w + bus_w - 1) / bus_w;
    endfunction

    // index width that always leaves at least one out-of-range code
    function automatic int index_width(input int words);
        return $clog2(words + 1);
    endfunction

    // width of the last (possibly partial) word
    function automatic int last_width(input int field_w, input int bus_w);
        return field_w - (word_count(field_w, bus_w) - 1) * bus_w;
    endfunction

endpackage

// File: rtl/scr_word_lane.sv
`timescale 1ns/1ps
module scr_word_lane #(
    parameter int BUS_W       = 32,
    parameter int LANE_W      = 32,
    parameter bit USE_BYTE_EN = 1'b1,
    localparam int BE_W       = BUS_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [BE_W-1:0]  wr_be,
    output logic [BUS_W-1:0] q
);

    logic [BUS_W-1:0] wmask;

    generate
        if (USE_BYTE_EN) begin : g_byte
            always_comb begin
                for (int b = 0; b < BUS_W; b++) begin
                    wmask[b] = wr_be[b / 8] && (b < LANE_W);
                end
            end
        end else begin : g_word
            logic unused_be;
            assign unused_be = ^wr_be;
            always_comb begin
                for (int b = 0; b < BUS_W; b++) begin
                    wmask[b] = (b < LANE_W);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (sel) begin
            q <= (q & ~wmask) | (wr_data & wmask);
        end
    end

endmodule

// File: rtl/scr_live_bank.sv
`timescale 1ns/1ps
module scr_live_bank #(
    parameter int FIELD_W = 224
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] d,
    output logic [FIELD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/scr_read_mux.sv
`timescale 1ns/1ps
module scr_read_mux #(
    parameter int BUS_W = 32,
    parameter int WORDS = 7,
    parameter int IDX_W = 3
) (
    input  logic [WORDS*BUS_W-1:0] words,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [BUS_W-1:0]       rd_data
);

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (rd_idx == IDX_W'(w)) begin
                rd_data = words[w*BUS_W +: BUS_W];
            end
        end
    end

endmodule

// File: rtl/scr_wide_reg.sv
`timescale 1ns/1ps
module scr_wide_reg
    import scr_pkg::*;
#(
    parameter int FIELD_W     = 224,
    parameter int BUS_W       = 32,
    parameter bit USE_BYTE_EN = 1'b1,
    localparam int WORDS      = word_count(FIELD_W, BUS_W),
    localparam int IDX_W      = index_width(WORDS),
    localparam int BE_W       = BUS_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic [BE_W-1:0]    wr_be,
    input  logic               commit,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [BUS_W-1:0]   rd_data,
    output logic [FIELD_W-1:0] live_val
);

    localparam int PAD_W  = WORDS * BUS_W;
    localparam int LAST_W = last_width(FIELD_W, BUS_W);

    logic [PAD_W-1:0]   shadow_pad;
    logic [FIELD_W-1:0] shadow_flat;

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_lane
            localparam int LW = (w == WORDS - 1) ? LAST_W : BUS_W;
            logic sel;
            logic [BUS_W-1:0] lane_q;

            assign sel = wr_en && (wr_idx == IDX_W'(w));

            scr_word_lane #(
                .BUS_W      (BUS_W),
                .LANE_W     (LW),
                .USE_BYTE_EN(USE_BYTE_EN)
            ) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel    (sel),
                .wr_data(wr_data),
                .wr_be  (wr_be),
                .q      (lane_q)
            );

            assign shadow_pad[w*BUS_W +: BUS_W] = lane_q;
        end

        if (PAD_W > FIELD_W) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^shadow_pad[PAD_W-1:FIELD_W];
        end
    endgenerate

    assign shadow_flat = shadow_pad[FIELD_W-1:0];

    scr_live_bank #(
        .FIELD_W(FIELD_W)
    ) u_live (
        .clk  (clk),
        .rst_n(rst_n),
        .load (commit),
        .d    (shadow_flat),
        .q    (live_val)
    );

    scr_read_mux #(
        .BUS_W(BUS_W),
        .WORDS(WORDS),
        .IDX_W(IDX_W)
    ) u_rd (
        .words  (shadow_pad),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/scr_wide_reg_chk.sv
`timescale 1ns/1ps
module scr_wide_reg_chk #(
    parameter int FIELD_W     = 224,
    parameter int BUS_W       = 32,
    parameter bit USE_BYTE_EN = 1'b1,
    parameter int WORDS       = 7,
    parameter int IDX_W       = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [BUS_W-1:0]   wr_data,
    input logic [BUS_W/8-1:0] wr_be,
    input logic               commit,
    input logic [IDX_W-1:0]   rd_idx,
    input logic [BUS_W-1:0]   rd_data,
    input logic [FIELD_W-1:0] live_val,
    input logic [FIELD_W-1:0] shadow_flat
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
    localparam logic [IDX_W-1:0] WORDS_I  = IDX_W'(WORDS);

    // R3: without commit the live value holds
    assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_val));

    // R4: commit loads the whole staged field
    assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> live_val == $past(shadow_flat));

    // R5: a write in the commit cycle is not part of the committed value
    assert_same_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wr_en) |=> live_val == $past(shadow_flat));

    // R2: a full-word write reads back on the next cycle
    assert_write_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == rd_idx && wr_idx < LAST_IDX && (!USE_BYTE_EN || (&wr_be)))
        |=> (!$stable(rd_idx) || rd_data == $past(wr_data)));

    // R6: out-of-range reads return zero
    assert_oor_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= WORDS_I) |-> rd_data == '0);

endmodule

bind scr_wide_reg scr_wide_reg_chk #(
    .FIELD_W    (FIELD_W),
    .BUS_W      (BUS_W),
    .USE_BYTE_EN(USE_BYTE_EN),
    .WORDS      (WORDS),
    .IDX_W      (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .commit     (commit),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .live_val   (live_val),
    .shadow_flat(shadow_flat)
);

// File: tb/test_scr_wide_reg.sv
`timescale 1ns/1ps
module test_scr_wide_reg;

    localparam int NW = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_idx = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   wr_be = '0;
    logic         commit = 1'b0;
    logic [2:0]   rd_idx = '0;
    logic [31:0]  rd_a, rd_b;
    logic [223:0] live_a, live_b;

    always #10 clk = ~clk;

    scr_wide_reg i_scr_wide_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_be(wr_be), .commit(commit),
        .rd_idx(rd_idx), .rd_data(rd_a), .live_val(live_a)
    );

    scr_wide_reg #(.USE_BYTE_EN(1'b0)) i_scr_wide_reg_nobe (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_be(wr_be), .commit(commit),
        .rd_idx(rd_idx), .rd_data(rd_b), .live_val(live_b)
    );

    typedef struct {
        string        tag;
        logic [31:0]  rd_a;
        logic [31:0]  rd_b;
        logic [223:0] lv_a;
        logic [223:0] lv_b;
    } item_t;

    item_t       sb[$];
    int          vectors = 0;
    int          miscompares = 0;
    logic [31:0] sh_a [NW];
    logic [31:0] sh_b [NW];
    logic [223:0] m_live_a = '0;
    logic [223:0] m_live_b = '0;

    function automatic logic [223:0] pack(input logic [31:0] s [NW]);
        logic [223:0] v;
        for (int w = 0; w < NW; w++) v[w*32 +: 32] = s[w];
        return v;
    endfunction

    // driver: applies one operation and queues what must follow it
    task automatic op(input logic we, input logic [2:0] idx, input logic [31:0] d,
                      input logic [3:0] be, input logic cm, input logic [2:0] ri,
                      input string tag);
        item_t it;
        @(posedge clk);
        #2;
        wr_en = we; wr_idx = idx; wr_data = d; wr_be = be; commit = cm; rd_idx = ri;
        if (cm) begin
            m_live_a = pack(sh_a);
            m_live_b = pack(sh_b);
        end
        if (we && idx < 3'(NW)) begin
            for (int k = 0; k < 4; k++)
                if (be[k]) sh_a[idx][k*8 +: 8] = d[k*8 +: 8];
            sh_b[idx] = d;
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0; commit = 1'b0;
        it.tag  = tag;
        it.rd_a = (ri < 3'(NW)) ? sh_a[ri] : 32'h0;
        it.rd_b = (ri < 3'(NW)) ? sh_b[ri] : 32'h0;
        it.lv_a = m_live_a;
        it.lv_b = m_live_b;
        sb.push_back(it);
    endtask

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            vectors += 4;
            if (rd_a !== it.rd_a) begin
                miscompares++;
                $display("FAIL %s rd_data: got %h expected %h", it.tag, rd_a, it.rd_a);
            end
            if (live_a !== it.lv_a) begin
                miscompares++;
                $display("FAIL %s live_val: got %h expected %h", it.tag, live_a, it.lv_a);
            end
            if (rd_b !== it.rd_b) begin
                miscompares++;
                $display("FAIL %s (R7 copy) rd_data: got %h expected %h", it.tag, rd_b, it.rd_b);
            end
            if (live_b !== it.lv_b) begin
                miscompares++;
                $display("FAIL %s (R7 copy) live_val: got %h expected %h", it.tag, live_b, it.lv_b);
            end
        end
    end

    initial begin
        #(20 * 100000);
        miscompares++;
        $display("FAIL watchdog expired, all requirements: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            sh_a[w] = '0;
            sh_b[w] = '0;
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset contents
        op(1'b0, 3'd0, 32'h0, 4'h0, 1'b0, 3'd0, "R1 reset word0");
        op(1'b0, 3'd0, 32'h0, 4'h0, 1'b0, 3'd6, "R1 reset word6");

        // R2/R3/R8: stage every word, live untouched
        for (int w = 0; w < NW; w++)
            op(1'b1, 3'(w), 32'hA000_0000 + 32'(w) * 32'h0101_0101, 4'hF, 1'b0, 3'(w),
               "R2 R3 R8 full-word stage");

        // R2/R7: partial byte write
        op(1'b1, 3'd2, 32'h1122_3344, 4'b0101, 1'b0, 3'd2, "R2 R7 byte-enable write");
        op(1'b1, 3'd5, 32'hDEAD_BEEF, 4'b1000, 1'b0, 3'd5, "R2 R7 top byte only");
        op(1'b1, 3'd4, 32'hCAFE_F00D, 4'b0000, 1'b0, 3'd4, "R2 R7 no byte enabled");

        // R4: commit everything
        op(1'b0, 3'd0, 32'h0, 4'h0, 1'b1, 3'd3, "R4 commit");

        // R5: write during commit
        op(1'b1, 3'd0, 32'h5555_AAAA, 4'hF, 1'b1, 3'd0, "R5 write with commit");
        op(1'b0, 3'd0, 32'h0, 4'h0, 1'b0, 3'd0, "R5 write not yet live");
        op(1'b0, 3'd0, 32'h0, 4'h0, 1'b1, 3'd0, "R4 later commit");
        op(1'b0, 3'd0, 32'h0, 4'h0, 1'b1, 3'd1, "R4 repeat commit");

        // R6: out-of-range index
        op(1'b1, 3'd7, 32'hFFFF_FFFF, 4'hF, 1'b0, 3'd7, "R6 out-of-range");
        op(1'b1, 3'd7, 32'h1234_5678, 4'hF, 1'b1, 3'd6, "R6 R4 oor write with commit");

        // R3/R8: half-written new value stays hidden
        op(1'b1, 3'd1, 32'h0BAD_0001, 4'hF, 1'b0, 3'd1, "R3 R8 partial update");
        op(1'b1, 3'd6, 32'h0BAD_0006, 4'b0011, 1'b0, 3'd6, "R3 R8 partial update");
        op(1'b0, 3'd0, 32'h0, 4'h0, 1'b1, 3'd6, "R4 commit partial update");

        // R1: reset after activity
        @(posedge clk);
        #2 rst_n = 1'b0;
        for (int w = 0; w < NW; w++) begin
            sh_a[w] = '0;
            sh_b[w] = '0;
        end
        m_live_a = '0;
        m_live_b = '0;
        @(posedge clk);
        #2 rst_n = 1'b1;
        op(1'b0, 3'd0, 32'h0, 4'h0, 1'b0, 3'd1, "R1 reset after use");

        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule